// File: doc/BRIEF.md
# Dual-Slope Integrating ADC Sequencer

This block sequences and times a two-phase integrating analog-to-digital converter. After a start strobe it first discharges the external integrator, then connects the unknown input to it for a fixed run-up of `RUNUP_CLKS` clocks. It then switches the integrator over to a reference source of opposite polarity and counts clocks until the zero-crossing comparator reports that the stored charge is gone. That count is the conversion code. It equals the input-to-reference ratio scaled by the run-up length. Integrator capacitance and slow clock drift affect both phases equally, so they cancel out of the code.

The comparator is asynchronous to the sequencer clock. It passes through a two-flop synchroniser. The synchroniser latency is subtracted from the raw run-down count, so the code is the number of reference clocks that elapsed before the comparator switched. If the comparator does not respond within the run-down window, the code saturates at full scale and an overrange flag is raised.

The states are IDLE, RESET_INT, RUN_UP, RUN_DOWN and DONE. The transitions are:
- IDLE→RESET_INT when start is sampled.
- RESET_INT→RUN_UP after `RST_CLKS` cycles.
- RUN_UP→RUN_DOWN after `RUNUP_CLKS` cycles.
- RUN_DOWN→DONE on a synchronised crossing or when the window expires.
- DONE→IDLE unconditionally.

Top module: `dual_slope_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy, done, overrange, result and all three switch selects are 0.
- R2: A start sampled high in IDLE sets busy in the next cycle and drives sel_rst high for exactly RST_CLKS (default 4) consecutive cycles.
- R3: sel_in is high for exactly RUNUP_CLKS (default 16) consecutive cycles, beginning in the cycle right after sel_rst falls; at most one select is high in any cycle.
- R4: sel_ref rises in the cycle sel_in falls. It stays high for k+3 cycles when the comparator (zc_in=1 meaning charge at or below zero) first reads high after k≥1 reference clocks. It stays high for 1 cycle when zc_in is already high as run-down starts. It stays high for RUNUP_CLKS+3 cycles when no crossing is seen in time.
- R5: result equals k, the number of reference clocks after which zc_in first reads high. For a behavioural integrator this is ceil(RUNUP_CLKS·vin/iref). result is 0 for zero input.
- R6: When k exceeds RUNUP_CLKS, result is RUNUP_CLKS and overrange is 1. When k equals RUNUP_CLKS exactly, result is RUNUP_CLKS and overrange is 0.
- R7: done is a one-cycle pulse that occurs RST_CLKS+RUNUP_CLKS+R cycles after the start edge, where R is the sel_ref duration of R4. busy is high from the cycle after start through the done cycle and is low in the cycle after done.
- R8: start is ignored while busy is high, including in the done cycle: timing and result of the running conversion are unchanged and no new conversion begins.
- R9: result and overrange change only at the edge that raises done and hold their value until the next done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request, sampled in IDLE |
| zc_in | input | 1 | Zero-crossing comparator, 1 when integrator charge is at or below zero |
| sel_rst | output | 1 | Close the integrator discharge switch |
| sel_in | output | 1 | Connect the unknown input to the integrator |
| sel_ref | output | 1 | Connect the opposite-polarity reference to the integrator |
| result | output | $clog2(RUNUP_CLKS+1) | Conversion code |
| overrange | output | 1 | Code saturated because no crossing was seen in the window |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The done pulse is due RST_CLKS+RUNUP_CLKS+R edges after the edge that samples start. R is 1 for a comparator that is already high, and k+3 otherwise: two synchroniser flops plus the state-change edge. The bench counts edges from the start edge and compares that count with this figure. It samples outputs on falling edges, so each value read is the one settled after the preceding rising edge. Select durations are measured by counting the falling-edge samples in which each select is high. result and overrange are read in the sample where done is first seen, and read again in later idle cycles.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RESET_INT,
        ST_RUN_UP,
        ST_RUN_DOWN,
        ST_DONE
    } seq_state_t;

    // flops between the comparator pin and the crossing detector
    localparam int SYNC_STAGES = 2;

endpackage

// File: rtl/zc_sync.sv
module zc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic zc_raw,
    output logic zc_hit
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], zc_raw};
        end
    end

    // previous synchronised level, forced low while disarmed so that a level
    // already high at arming counts as a crossing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else if (!arm) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= chain_q[STAGES-1];
        end
    end

    assign zc_hit = arm & chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/phase_counter.sv
module phase_counter #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + W'(1);
        end
    end

endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
    import dsadc_pkg::*;
#(
    parameter int RUNUP_CLKS = 16,
    parameter int RST_CLKS   = 4,
    localparam int RW        = $clog2(RUNUP_CLKS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          zc_in,
    output logic          sel_rst,
    output logic          sel_in,
    output logic          sel_ref,
    output logic [RW-1:0] result,
    output logic          overrange,
    output logic          busy,
    output logic          done
);

    localparam int MAXC = (RUNUP_CLKS + SYNC_STAGES > RST_CLKS) ?
                          (RUNUP_CLKS + SYNC_STAGES) : RST_CLKS;
    localparam int CW   = $clog2(MAXC + 1);

    localparam logic [CW-1:0] RST_LAST   = CW'(RST_CLKS - 1);
    localparam logic [CW-1:0] RUNUP_LAST = CW'(RUNUP_CLKS - 1);
    localparam logic [CW-1:0] WIN_LAST   = CW'(RUNUP_CLKS + SYNC_STAGES);
    localparam logic [CW-1:0] LAT        = CW'(SYNC_STAGES);
    localparam logic [RW-1:0] FULL_SCALE = RW'(RUNUP_CLKS);

    seq_state_t    state_q, state_d;
    logic [CW-1:0] cnt;
    logic          zc_hit;
    logic          phase_chg;
    logic          arm;

    assign phase_chg = (state_d != state_q);
    assign arm       = (state_q == ST_RUN_DOWN);

    zc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (arm),
        .zc_raw (zc_in),
        .zc_hit (zc_hit)
    );

    phase_counter #(.W(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (phase_chg),
        .inc   (state_q != ST_IDLE),
        .count (cnt)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start)                  state_d = ST_RESET_INT;
            ST_RESET_INT: if (cnt == RST_LAST)        state_d = ST_RUN_UP;
            ST_RUN_UP:    if (cnt == RUNUP_LAST)      state_d = ST_RUN_DOWN;
            ST_RUN_DOWN:  if (zc_hit || cnt == WIN_LAST) state_d = ST_DONE;
            ST_DONE:                                  state_d = ST_IDLE;
            default:                                  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // code capture, with synchroniser latency removed from the raw count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result    <= '0;
            overrange <= 1'b0;
        end else if (arm && state_d == ST_DONE) begin
            if (zc_hit) begin
                result    <= (cnt >= LAT) ? RW'(cnt - LAT) : '0;
                overrange <= 1'b0;
            end else begin
                result    <= FULL_SCALE;
                overrange <= 1'b1;
            end
        end
    end

    // switch selects and flags decoded from the state
    always_comb begin
        sel_rst = 1'b0;
        sel_in  = 1'b0;
        sel_ref = 1'b0;
        done    = 1'b0;
        busy    = 1'b1;
        unique case (state_q)
            ST_IDLE:      busy    = 1'b0;
            ST_RESET_INT: sel_rst = 1'b1;
            ST_RUN_UP:    sel_in  = 1'b1;
            ST_RUN_DOWN:  sel_ref = 1'b1;
            ST_DONE:      done    = 1'b1;
            default:      busy    = 1'b0;
        endcase
    end

    AST_SEL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_rst, sel_in, sel_ref})); // R3
    AST_RUNUP_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_in) |-> $past(sel_rst)); // R3
    AST_REF_AFTER_RUNUP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sel_in) |-> sel_ref); // R4
    AST_RESULT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result <= FULL_SCALE)); // R5
    AST_OVR_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && overrange) |-> (result == FULL_SCALE)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R7
    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R8
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({result, overrange}) |-> done); // R9

endmodule

// File: tb/tb_dual_slope_seq.sv
module tb_dual_slope_seq;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 16;
    localparam int RSTC       = 4;
    localparam int RW         = $clog2(N + 1);

    localparam int NVEC = 8;
    localparam int T_VIN  [NVEC] = '{0, 5, 10, 11, 3, 1, 7, 17};
    localparam int T_IREF [NVEC] = '{10, 10, 10, 10, 7, 16, 8, 1};
    localparam int T_CODE [NVEC] = '{0, 8, 16, 16, 7, 1, 14, 16};
    localparam int T_OVR  [NVEC] = '{0, 0, 0, 1, 0, 0, 0, 1};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          zc_in;
    logic          sel_rst, sel_in, sel_ref;
    logic [RW-1:0] result;
    logic          overrange, busy, done;

    int checks = 0;
    int failures = 0;
    int charge = 0;
    int vin = 0;
    int iref = 1;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dual_slope_seq #(.RUNUP_CLKS(N), .RST_CLKS(RSTC)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .zc_in     (zc_in),
        .sel_rst   (sel_rst),
        .sel_in    (sel_in),
        .sel_ref   (sel_ref),
        .result    (result),
        .overrange (overrange),
        .busy      (busy),
        .done      (done)
    );

    // behavioural integrator and comparator
    always @(posedge clk) begin
        if (sel_rst)      charge <= 0;
        else if (sel_in)  charge <= charge + vin;
        else if (sel_ref) charge <= charge - iref;
    end
    assign zc_in = (charge <= 0);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_conv(input int v, input int r, input int extra,
                            output int cyc, output int nrst, output int nin,
                            output int nref, output int nidle);
        vin = v; iref = r;
        cyc = 0; nrst = 0; nin = 0; nref = 0; nidle = 0;
        @(negedge clk); start = 1'b1;
        @(posedge clk);
        forever begin
            @(negedge clk);
            start = (cyc == extra);
            if (sel_rst) nrst++;
            if (sel_in)  nin++;
            if (sel_ref) nref++;
            if (!busy)   nidle++;
            if (done) break;
            if (cyc > 600) begin
                chk("R7 conversion hung", cyc, 0);
                break;
            end
            @(posedge clk);
            cyc++;
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int cyc, nrst, nin, nref, nidle, rd, last_res;

        repeat (3) @(negedge clk);
        chk("R1 busy in reset", int'(busy), 0);
        chk("R1 selects in reset", int'({sel_rst, sel_in, sel_ref}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done after reset", int'(done), 0);
        chk("R1 result after reset", int'(result), 0);
        chk("R1 overrange after reset", int'(overrange), 0);

        // vector table walk
        for (int i = 0; i < NVEC; i++) begin
            run_conv(T_VIN[i], T_IREF[i], -1, cyc, nrst, nin, nref, nidle);
            rd = T_OVR[i] ? N + 3 : (T_CODE[i] == 0 ? 1 : T_CODE[i] + 3);
            chk($sformatf("R2 reset length vec%0d", i), nrst, RSTC);
            chk($sformatf("R3 run-up length vec%0d", i), nin, N);
            chk($sformatf("R4 run-down length vec%0d", i), nref, rd);
            chk($sformatf("R5 code vec%0d", i), int'(result), T_CODE[i]);
            chk($sformatf("R6 overrange vec%0d", i), int'(overrange), T_OVR[i]);
            chk($sformatf("R7 done latency vec%0d", i), cyc, RSTC + N + rd);
            chk($sformatf("R7 busy gaps vec%0d", i), nidle, 0);
            @(negedge clk);
            chk($sformatf("R7 done pulse width vec%0d", i), int'(done), 0);
            chk($sformatf("R7 busy after done vec%0d", i), int'(busy), 0);
        end

        // R9: result held through idle cycles
        last_res = int'(result);
        repeat (5) @(negedge clk);
        chk("R9 result held in idle", int'(result), last_res);
        chk("R9 overrange held in idle", int'(overrange), 1);

        // R8: start pulses during run-up and run-down are ignored
        run_conv(5, 10, 8, cyc, nrst, nin, nref, nidle);
        chk("R8 code with start in run-up", int'(result), 8);
        chk("R8 latency with start in run-up", cyc, RSTC + N + 11);
        run_conv(3, 7, RSTC + N + 2, cyc, nrst, nin, nref, nidle);
        chk("R8 code with start in run-down", int'(result), 7);
        chk("R8 latency with start in run-down", cyc, RSTC + N + 10);
        chk("R8 run-up count unchanged", nin, N);

        // R8: start in the done cycle is ignored
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R8 start in done cycle busy", int'(busy), 0);
        @(negedge clk);
        chk("R8 no conversion after done-cycle start", int'(sel_rst), 0);
        chk("R9 result kept after ignored start", int'(result), 7);

        // R1: reset in the middle of a conversion
        vin = 5; iref = 10;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (8) @(negedge clk);
        chk("R3 mid-run in run-up", int'(sel_in), 1);
        rst_n = 1'b0;
        #1;
        chk("R1 busy cleared by reset", int'(busy), 0);
        chk("R1 selects cleared by reset", int'({sel_rst, sel_in, sel_ref}), 0);
        chk("R1 result cleared by reset", int'(result), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset release", int'(busy), 0);

        // a normal conversion after the interrupted one
        run_conv(7, 8, -1, cyc, nrst, nin, nref, nidle);
        chk("R5 code after interrupted run", int'(result), 14);
        chk("R7 latency after interrupted run", cyc, RSTC + N + 17);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule